// File: doc/BRIEF.md
# Flash identify and quad-enable sequencer

This block runs a fixed bring-up sequence on a serial flash once after reset, so that the flash is left in a state where four-lane transfers are allowed. A small byte shifter for SPI mode 0 is built into the block. The sequencer first clocks two filler bytes with chip select high, so that the flash's interface is in a known state. It then reads the identifier bytes and compares them with a parameter. On a mismatch it stops and reports failure.

When the identifier matches, the block reads the second status register. It checks the quad-enable bit in that register. If the bit is already set, the block finishes at once. If the bit is clear, the block sends a write-enable frame, then a three-byte status write that sets the bit. It then polls the first status register until the busy flag clears, and only then reports completion.

The two result outputs are sticky until the next reset. The expected identifier is a parameter, so another flash can be accepted without any change to the logic.

Top module: `flash_init_seq`

## Requirements
- R1: While reset is held, spi_cs_n is 1, spi_sck is 0, and both init_done and init_fail are 0.
- R2: After reset, exactly 16 rising edges of spi_sck (two filler bytes) occur with spi_cs_n high before the first frame. No other edge of spi_sck ever occurs with chip select high.
- R3: The bus runs in SPI mode 0 with the most significant bit first. spi_mosi changes only while spi_sck is low. spi_miso is sampled on the rising edge of spi_sck. spi_sck is low whenever spi_cs_n changes.
- R4: The first frame is 4 bytes long: opcode 0x9F followed by 3 captured bytes. The first captured byte is compared with EXPECT_ID[23:16], the second with [15:8] and the third with [7:0].
- R5: If any identifier byte differs, init_fail rises and no further frame is issued.
- R6: After a match, a 2-byte frame reads the second status register with opcode 0x35.
- R7: If bit 1 (mask 0x02) of that status byte is 1, init_done rises with no write frames. All other bits of the status byte have no effect.
- R8: If bit 1 is 0, a 1-byte frame with opcode 0x06 is sent, then a 3-byte frame with the bytes 0x01, 0x00, 0x02.
- R9: After the status write, the block repeats 2-byte frames with opcode 0x05 until bit 0 of the returned byte is 0, then raises init_done. The other returned bits are ignored.
- R10: init_done and init_fail are never high together. Once set, each stays set until reset, and the bus stays idle.
- R11: Between any two frames, spi_cs_n stays high for at least GAP_CYCLES clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sck | output | 1 | Serial clock to the flash, idles low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| init_done | output | 1 | Sequence finished with quad mode enabled (sticky) |
| init_fail | output | 1 | Identifier mismatch (sticky) |

## Verification
The bench uses a behavioural flash model that returns configurable identifier and status bytes. The corner cases it covers are these: a wrong first byte or a wrong last identifier byte, a status byte with only the quad bit set, and a status byte with every bit except the quad bit set. A design that compared too few bytes, or compared them in the wrong order, would report completion instead of failure. A design that tested the wrong status bit would either skip the write or issue it needlessly. Busy-poll counts from zero to several, with random noise in the upper status bits, expose a design that stops polling early or misreads the busy flag. Frame lengths, the filler edge count and the chip-select gaps are all measured, so a frame merged into its neighbour or a filler byte clocked with chip select low also shows up.

// File: rtl/flash_init_pkg.sv
package flash_init_pkg;
   typedef enum logic [3:0] {
      ST_DUMMY, ST_IDENT, ST_RDSR2, ST_WREN, ST_WRSR, ST_POLL, ST_GAP, ST_DONE, ST_FAIL
   } fi_step_e;

   localparam logic [7:0] OPC_IDENT = 8'h9F;
   localparam logic [7:0] OPC_RDSR2 = 8'h35;
   localparam logic [7:0] OPC_WREN  = 8'h06;
   localparam logic [7:0] OPC_WRSR  = 8'h01;
   localparam logic [7:0] OPC_RDSR1 = 8'h05;
   localparam logic [7:0] FILL_BYTE = 8'hFF;
   localparam logic [7:0] QE_MASK   = 8'h02;
   localparam logic [7:0] SR1_KEEP  = 8'h00;
   localparam int         BUSY_BIT    = 0;
   localparam int         DUMMY_BYTES = 2;
endpackage

// File: rtl/fi_byte_shift.sv
module fi_byte_shift #(
   parameter int DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       busy,
   output logic       done,
   output logic [7:0] rx
);
   logic [7:0] sh_q;
   logic [2:0] bit_q;
   logic       tick;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("fi_byte_shift: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      cnt_q <= '0;
            else if (!busy)                  cnt_q <= '0;
            else if (cnt_q == CW'(DIV - 1))  cnt_q <= '0;
            else                             cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == CW'(DIV - 1));
      end
   endgenerate

   assign mosi = sh_q[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         bit_q <= '0;
         sck   <= 1'b0;
         busy  <= 1'b0;
         done  <= 1'b0;
         rx    <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy  <= 1'b1;
               sh_q  <= tx;
               bit_q <= '0;
               sck   <= 1'b0;
            end
         end else if (tick) begin
            if (!sck) begin
               sck <= 1'b1;
               rx  <= {rx[6:0], miso};
            end else begin
               sck <= 1'b0;
               if (bit_q == 3'd7) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bit_q <= bit_q + 3'd1;
                  sh_q  <= {sh_q[6:0], 1'b0};
               end
            end
         end
      end
   end
endmodule

// File: rtl/fi_id_match.sv
module fi_id_match #(
   parameter int NB = 3
) (
   input  logic [8*NB-1:0] got,
   input  logic [8*NB-1:0] want,
   output logic            hit
);
   logic [NB-1:0] eq;
   generate
      for (genvar i = 0; i < NB; i++) begin : g_byte
         assign eq[i] = (got[8*i +: 8] == want[8*i +: 8]);
      end
   endgenerate
   assign hit = &eq;
endmodule

// File: rtl/flash_init_seq.sv
module flash_init_seq
   import flash_init_pkg::*;
#(
   parameter int                  CLK_DIV    = 2,
   parameter int                  GAP_CYCLES = 4,
   parameter int                  ID_BYTES   = 3,
   parameter logic [8*ID_BYTES-1:0] EXPECT_ID = 24'hEF4017
) (
   input  logic clk,
   input  logic rst_n,
   output logic spi_sck,
   output logic spi_cs_n,
   output logic spi_mosi,
   input  logic spi_miso,
   output logic init_done,
   output logic init_fail
);
   localparam int IW  = $clog2(ID_BYTES + 2);
   localparam int GW  = $clog2(GAP_CYCLES + 1);
   localparam int IDW = 8 * ID_BYTES;

   generate
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("flash_init_seq: GAP_CYCLES must be at least 1");
      end
      if (ID_BYTES < 1) begin : g_bad_id
         $error("flash_init_seq: ID_BYTES must be at least 1");
      end
   endgenerate

   fi_step_e       state_q, next_q, after;
   logic [IW-1:0]  idx_q;
   logic [GW-1:0]  gap_q;
   logic [IDW-1:0] id_q, id_next;
   logic           launched_q, in_frame, hit;
   logic           eng_start, eng_busy, eng_done;
   logic [7:0]     eng_tx, eng_rx;

   function automatic logic [IW-1:0] last_idx(fi_step_e s);
      case (s)
         ST_DUMMY: return IW'(DUMMY_BYTES - 1);
         ST_IDENT: return IW'(ID_BYTES);
         ST_RDSR2: return IW'(1);
         ST_WRSR:  return IW'(2);
         ST_POLL:  return IW'(1);
         default:  return '0;
      endcase
   endfunction

   function automatic logic [7:0] tx_byte(fi_step_e s, logic [IW-1:0] i);
      case (s)
         ST_IDENT: return (i == '0) ? OPC_IDENT : FILL_BYTE;
         ST_RDSR2: return (i == '0) ? OPC_RDSR2 : FILL_BYTE;
         ST_WREN:  return OPC_WREN;
         ST_WRSR:  return (i == '0) ? OPC_WRSR : ((i == IW'(1)) ? SR1_KEEP : QE_MASK);
         ST_POLL:  return (i == '0) ? OPC_RDSR1 : FILL_BYTE;
         default:  return FILL_BYTE;
      endcase
   endfunction

   always_comb begin
      case (state_q)
         ST_DUMMY, ST_IDENT, ST_RDSR2, ST_WREN, ST_WRSR, ST_POLL: in_frame = 1'b1;
         default: in_frame = 1'b0;
      endcase
   end

   assign spi_cs_n  = !(in_frame && (state_q != ST_DUMMY));
   assign eng_start = in_frame && !launched_q && !eng_busy;
   assign eng_tx    = tx_byte(state_q, idx_q);
   assign init_done = (state_q == ST_DONE);
   assign init_fail = (state_q == ST_FAIL);

   generate
      if (ID_BYTES == 1) begin : g_id1
         assign id_next = eng_rx;
      end else begin : g_idn
         assign id_next = {id_q[IDW-9:0], eng_rx};
      end
   endgenerate

   fi_id_match #(.NB(ID_BYTES)) u_match (
      .got  (id_next),
      .want (EXPECT_ID),
      .hit  (hit)
   );

   fi_byte_shift #(.DIV(CLK_DIV)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .start (eng_start),
      .tx    (eng_tx),
      .miso  (spi_miso),
      .sck   (spi_sck),
      .mosi  (spi_mosi),
      .busy  (eng_busy),
      .done  (eng_done),
      .rx    (eng_rx)
   );

   always_comb begin
      case (state_q)
         ST_DUMMY: after = ST_IDENT;
         ST_IDENT: after = hit ? ST_RDSR2 : ST_FAIL;
         ST_RDSR2: after = ((eng_rx & QE_MASK) != 8'h00) ? ST_DONE : ST_WREN;
         ST_WREN:  after = ST_WRSR;
         ST_WRSR:  after = ST_POLL;
         ST_POLL:  after = eng_rx[BUSY_BIT] ? ST_POLL : ST_DONE;
         default:  after = state_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_DUMMY;
         next_q     <= ST_DUMMY;
         idx_q      <= '0;
         gap_q      <= '0;
         id_q       <= '0;
         launched_q <= 1'b0;
      end else begin
         case (state_q)
            ST_GAP: begin
               if (gap_q == GW'(GAP_CYCLES - 1)) begin
                  gap_q   <= '0;
                  state_q <= next_q;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            ST_DONE, ST_FAIL: ;
            default: begin
               if (eng_start) launched_q <= 1'b1;
               if (eng_done) begin
                  launched_q <= 1'b0;
                  if (state_q == ST_IDENT && idx_q != '0) id_q <= id_next;
                  if (idx_q == last_idx(state_q)) begin
                     idx_q   <= '0;
                     next_q  <= after;
                     state_q <= ST_GAP;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/flash_init_chk.sv
module flash_init_chk (
   input logic clk,
   input logic rst_n,
   input logic spi_sck,
   input logic spi_cs_n,
   input logic spi_mosi,
   input logic init_done,
   input logic init_fail
);
   assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

   assert_cs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs_n != $past(spi_cs_n)) |-> !spi_sck);

   assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(init_done && init_fail));

   assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      init_fail |=> init_fail);

   assert_quiet_after_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (init_done || init_fail) |-> (spi_cs_n && !spi_sck));
endmodule

bind flash_init_seq flash_init_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .spi_sck   (spi_sck),
   .spi_cs_n  (spi_cs_n),
   .spi_mosi  (spi_mosi),
   .init_done (init_done),
   .init_fail (init_fail)
);

// File: tb/tb_flash_init_seq.sv
`timescale 1ns/1ps
module tb_flash_init_seq;
   localparam int          DIV = 2;
   localparam int          GAP = 4;
   localparam logic [23:0] EXP = 24'hEF4017;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sck, spi_cs_n, spi_mosi, init_done, init_fail;
   logic spi_miso;

   always #10 clk = ~clk;

   flash_init_seq #(.CLK_DIV(DIV), .GAP_CYCLES(GAP), .ID_BYTES(3), .EXPECT_ID(EXP)) dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .init_done(init_done), .init_fail(init_fail)
   );

   // flash model configuration, written by the stimulus only
   logic [7:0] cfg_id0, cfg_id1, cfg_id2, cfg_sr2, cfg_noise;
   int         cfg_polls;

   // flash model state, written by the model process only
   logic [7:0] fr_b [0:31][0:3];
   int         fr_len [0:31];
   int         fc, bidx, bitcnt, dummy_edges, all_edges, mode_err, cs_err, gap, min_gap, busy_left;
   logic [7:0] in_sh, out_sh, op;
   logic       sck_p, cs_p, mosi_p;

   assign spi_miso = out_sh[7];

   function automatic logic [7:0] resp(logic [7:0] o, int k);
      if (o == 8'h9F) return (k == 1) ? cfg_id0 : (k == 2) ? cfg_id1 : (k == 3) ? cfg_id2 : 8'hFF;
      if (o == 8'h35) return cfg_sr2;
      if (o == 8'h05) return {cfg_noise[7:1], (busy_left > 0)};
      return 8'hFF;
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         fc = 0; bidx = 0; bitcnt = 0; dummy_edges = 0; all_edges = 0;
         mode_err = 0; cs_err = 0; gap = 0; min_gap = 1000000; busy_left = 0;
         in_sh = 0; out_sh = 8'hFF; op = 0; sck_p = 0; cs_p = 1; mosi_p = 0;
      end else begin
         if (spi_cs_n != cs_p && spi_sck) cs_err++;
         if (spi_sck && sck_p && spi_mosi != mosi_p) mode_err++;
         if (!spi_cs_n && cs_p) begin
            bitcnt = 0; bidx = 0; op = 0; out_sh = 8'hFF;
            if (fc > 0 && gap < min_gap) min_gap = gap;
         end
         if (spi_cs_n && !cs_p) begin
            if (fc < 32) fr_len[fc] = bidx;
            if (op == 8'h01 && bidx == 3) busy_left = cfg_polls;
            if (op == 8'h05 && bidx >= 2 && busy_left > 0) busy_left--;
            fc++;
            gap = 0;
         end
         if (spi_cs_n) gap++;
         if (spi_sck && !sck_p) begin
            all_edges++;
            if (spi_cs_n) dummy_edges++;
            else begin
               in_sh = {in_sh[6:0], spi_mosi};
               bitcnt++;
               if (bitcnt % 8 == 0) begin
                  if (bidx == 0) op = in_sh;
                  if (fc < 32 && bidx < 4) fr_b[fc][bidx] = in_sh;
                  bidx++;
                  out_sh = resp(op, bidx);
               end else begin
                  out_sh = {out_sh[6:0], 1'b1};
               end
            end
         end
         sck_p = spi_sck; cs_p = spi_cs_n; mosi_p = spi_mosi;
      end
   end

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run(input logic [7:0] i0, input logic [7:0] i1, input logic [7:0] i2,
                      input logic [7:0] sr2, input int polls, input logic [7:0] noise);
      bit id_ok, skip;
      int nexp, t, edges0;
      cfg_id0 = i0; cfg_id1 = i1; cfg_id2 = i2; cfg_sr2 = sr2; cfg_polls = polls; cfg_noise = noise;
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(spi_cs_n && !spi_sck && !init_done && !init_fail, "R1", "idle in reset",
          {spi_cs_n, spi_sck, init_done, init_fail}, 4'b1000);
      rst_n = 1'b1;
      t = 0;
      while (!(init_done || init_fail) && t < 20000) begin @(negedge clk); t++; end
      chk(t < 20000, "R10", "completion watchdog", t, 0);
      id_ok = ({i0, i1, i2} == EXP);
      skip  = (sr2 & 8'h02) != 8'h00;
      nexp  = !id_ok ? 1 : skip ? 2 : 5 + polls;
      edges0 = all_edges;
      repeat (40) @(negedge clk);
      chk(init_done == (id_ok) && init_fail == !id_ok, id_ok ? "R7" : "R5", "outcome",
          {init_done, init_fail}, {id_ok, !id_ok});
      chk(all_edges == edges0 && (init_done || init_fail), "R10", "quiet and sticky", all_edges - edges0, 0);
      chk(fc == nexp, id_ok ? "R9" : "R5", "frame count", fc, nexp);
      chk(dummy_edges == 16, "R2", "filler edges", dummy_edges, 16);
      chk(mode_err == 0 && cs_err == 0, "R3", "mode 0 framing", mode_err + cs_err, 0);
      if (fc > 1) chk(min_gap >= GAP, "R11", "cs gap", min_gap, GAP);
      if (fc >= 1) chk(fr_len[0] == 4 && fr_b[0][0] == 8'h9F, "R4", "ident frame", fr_b[0][0], 8'h9F);
      if (id_ok && fc >= 2) chk(fr_len[1] == 2 && fr_b[1][0] == 8'h35, "R6", "status2 frame", fr_b[1][0], 8'h35);
      if (id_ok && !skip && fc >= 4) begin
         chk(fr_len[2] == 1 && fr_b[2][0] == 8'h06, "R8", "write enable frame", fr_b[2][0], 8'h06);
         chk(fr_len[3] == 3 && {fr_b[3][0], fr_b[3][1], fr_b[3][2]} == 24'h010002, "R8",
             "status write frame", {fr_b[3][0], fr_b[3][1], fr_b[3][2]}, 24'h010002);
         for (int k = 4; k < fc && k < 32; k++)
            chk(fr_len[k] == 2 && fr_b[k][0] == 8'h05, "R9", "busy poll frame", fr_b[k][0], 8'h05);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // directed corner cases
      run(8'hEF, 8'h40, 8'h17, 8'h02, 0, 8'h00);   // quad bit already set
      run(8'hEF, 8'h40, 8'h17, 8'hFD, 0, 8'hFE);   // all bits but quad set
      run(8'hEF, 8'h40, 8'h17, 8'h00, 3, 8'hAA);   // several busy polls
      run(8'hEE, 8'h40, 8'h17, 8'h00, 0, 8'h00);   // first id byte wrong
      run(8'hEF, 8'h40, 8'h16, 8'h00, 0, 8'h00);   // last id byte wrong
      run(8'h17, 8'h40, 8'hEF, 8'h02, 0, 8'h00);   // id bytes in reverse order
      // constrained random
      for (int n = 0; n < 24; n++) begin
         logic [23:0] id;
         logic [7:0]  s;
         id = EXP;
         if ($urandom_range(0, 3) == 0) id[8*$urandom_range(0, 2) +: 8] ^= 8'($urandom_range(1, 255));
         s = 8'($urandom);
         run(id[23:16], id[15:8], id[7:0], s, $urandom_range(0, 4), 8'($urandom));
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule